// File: doc/BRIEF.md
# Regulator Control Register Bank

This block is the register file behind the serial control port of a multi-rail power supply. A bus front end decodes the transfers and hands this block a write strobe with an address and a byte, and a read address. The block stores the control bytes and drives the enable and voltage-select lines for nine regulated rails and for the boost converter feeding the high-voltage rail. It also returns any register's contents on the read port. Address 00h holds a fixed version code and the software reset bit.

The block has three reset sources, and each one clears a different set of state. The active-low hardware reset clears everything, including the software reset bit. The software reset bit clears every other register and holds it cleared; while the bit is set, only address 00h accepts writes. The undervoltage input clears every register except address 00h. Enable outputs are registered. They are forced low while the software reset or the undervoltage signal is active.

Top module: `rail_ctl_regs`

## Requirements
- R1: After the hardware reset, every enable output is 0, neg_lvl and hi_lvl are 3'b001, vsel is 0, address 00h reads 20h and addresses 01h to 04h read 00h.
- R2: Address 00h reads {3'b001, 4'b0000, soft reset bit}. Only data bit 0 of a write to 00h is stored.
- R3: Address 01h stores data bits [6:0] and reads back {1'b0, bits[6:0]}. One clock edge after the write edge, rail_en[6:0] equals those bits.
- R4: Address 04h stores data bits 3, 2 and 0. It reads back data & 0Dh, so bit 1 and bits [7:4] read 0. One edge after the write edge, rail_en[8] is bit 3, rail_en[7] is bit 2 and boost_en is bit 0.
- R5: Address 02h stores data bits [7:4] and reads back data & F0h. neg_lvl is decoded from bits [7:6] as one-hot: 00→001 (-8 V), 01→010 (-7.5 V), 10 or 11→100 (-7 V). hi_lvl is decoded from bits [5:4]: 00→001 (14.5 V), 01→010 (15 V), 10 or 11→100 (13 V).
- R6: Address 03h stores data bits 7, 6, 5, 2 and 0 and reads back data & E5h. vsel equals {bit7, bit6, bit5, bit2, bit0}.
- R7: Writing 1 to bit 0 of 00h clears the registers at 01h to 04h. They stay clear while the bit is 1.
- R8: While the soft reset bit is 1, writes to 01h to 04h are ignored. Writing 0 to 00h releases the reset, and later writes take effect again.
- R9: Driving rst_n low clears every register, including the soft reset bit, so a pending software reset is cancelled.
- R10: While uvlo is high, the registers at 01h to 04h are cleared and writes to them are ignored. The soft reset bit at 00h keeps its value.
- R11: Writes to addresses 05h to 07h change no output and no readable register. Reads of those addresses return 00h.
- R12: rail_en and boost_en are 0 one edge after any edge at which uvlo or the soft reset bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| uvlo | input | 1 | Undervoltage lockout, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW (8) | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | AW (8) | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| rail_en | output | 9 | Registered rail enables |
| boost_en | output | 1 | Registered boost converter enable |
| neg_lvl | output | 3 | One-hot negative rail level |
| hi_lvl | output | 3 | One-hot high rail level |
| vsel | output | 5 | Single-bit voltage selects |

## Verification
The bench sweeps every data value into addresses 01h to 04h and checks the read-back masks and the decoded outputs. A design that masked the wrong bits, such as leaving bit 1 of 04h writable, would fail these checks. A design that decoded the 11 codes as a fourth level would also fail them.

The bench then checks how the reset sources interact:
- It writes to locked registers while the soft reset bit is set. A design that let those writes through, or that dropped the release write, would fail.
- It raises undervoltage with the soft reset bit set. A design that cleared 00h as well would fail.
- It pulses the hardware reset during a soft reset. A design that left the soft reset pending would fail.

Reserved addresses are written with all ones. A design with an address decode that aliases onto a real register would fail these checks.

// File: rtl/rail_ctl_regs.sv
module rail_ctl_regs #(
  parameter logic [2:0] VERSION = 3'b001,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uvlo,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [8:0]    rail_en,
  output logic          boost_en,
  output logic [2:0]    neg_lvl,
  output logic [2:0]    hi_lvl,
  output logic [4:0]    vsel
);
  localparam logic [AW-1:0] A_ID  = AW'(0);
  localparam logic [AW-1:0] A_EN1 = AW'(1);
  localparam logic [AW-1:0] A_LVL = AW'(2);
  localparam logic [AW-1:0] A_SEL = AW'(3);
  localparam logic [AW-1:0] A_EN2 = AW'(4);

  logic       soft_rst;
  logic [6:0] en_a;
  logic [3:0] lvl;
  logic [4:0] sel_q;
  logic [2:0] en_b;

  wire id_wr   = wr_en && (wr_addr == A_ID);
  wire srst_go = id_wr && wr_data[0];
  wire clr     = uvlo || soft_rst || srst_go;
  wire hold    = uvlo || soft_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     soft_rst <= 1'b0;
    else if (id_wr) soft_rst <= wr_data[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_a  <= '0;
      lvl   <= '0;
      sel_q <= '0;
      en_b  <= '0;
    end else if (clr) begin
      en_a  <= '0;
      lvl   <= '0;
      sel_q <= '0;
      en_b  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_EN1) en_a  <= wr_data[6:0];
      if (wr_addr == A_LVL) lvl   <= wr_data[7:4];
      if (wr_addr == A_SEL) sel_q <= {wr_data[7:5], wr_data[2], wr_data[0]};
      if (wr_addr == A_EN2) en_b  <= {wr_data[3:2], wr_data[0]};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rail_en  <= '0;
      boost_en <= 1'b0;
    end else begin
      rail_en  <= hold ? 9'd0 : {en_b[2:1], en_a};
      boost_en <= ~hold & en_b[0];
    end

  assign neg_lvl = lvl[3] ? 3'b100 : (lvl[2] ? 3'b010 : 3'b001);
  assign hi_lvl  = lvl[1] ? 3'b100 : (lvl[0] ? 3'b010 : 3'b001);
  assign vsel    = sel_q;

  always_comb
    case (rd_addr)
      A_ID:    rd_data = {VERSION, 4'b0000, soft_rst};
      A_EN1:   rd_data = {1'b0, en_a};
      A_LVL:   rd_data = {lvl, 4'b0000};
      A_SEL:   rd_data = {sel_q[4:2], 2'b00, sel_q[1], 1'b0, sel_q[0]};
      A_EN2:   rd_data = {4'b0000, en_b[2:1], 1'b0, en_b[0]};
      default: rd_data = 8'h00;
    endcase
endmodule

// File: rtl/rail_ctl_regs_chk.sv
module rail_ctl_regs_chk #(
  parameter logic [2:0] VERSION = 3'b001,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uvlo,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic [8:0]    rail_en,
  input logic          boost_en,
  input logic [2:0]    neg_lvl,
  input logic [2:0]    hi_lvl,
  input logic [4:0]    vsel,
  input logic          soft_rst
);
  wire rsv_wr = wr_en && (wr_addr >= AW'(5)) && (wr_addr <= AW'(7));

  a_r12_srst_gates: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rail_en == 9'd0) && !boost_en);

  a_r12_uvlo_gates: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (rail_en == 9'd0) && !boost_en);

  a_r10_uvlo_clears: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (neg_lvl == 3'b001) && (hi_lvl == 3'b001) && (vsel == 5'd0));

  a_r8_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (neg_lvl == 3'b001) && (hi_lvl == 3'b001) && (vsel == 5'd0));

  a_r5_onehot_levels: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(neg_lvl) == 1) && ($countones(hi_lvl) == 1));

  a_r2_version_field: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(0)) |-> (rd_data[7:5] == VERSION) && (rd_data[4:1] == 4'd0));

  a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_wr && !uvlo && !soft_rst) |=> $stable(neg_lvl) && $stable(hi_lvl) && $stable(vsel));
endmodule

bind rail_ctl_regs rail_ctl_regs_chk #(.VERSION(VERSION), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .rd_data(rd_data), .rail_en(rail_en), .boost_en(boost_en),
  .neg_lvl(neg_lvl), .hi_lvl(hi_lvl), .vsel(vsel), .soft_rst(soft_rst)
);

// File: tb/rail_ctl_regs_bench.sv
module rail_ctl_regs_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, uvlo = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic [8:0] rail_en;
  logic boost_en;
  logic [2:0] neg_lvl, hi_lvl;
  logic [4:0] vsel;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  rail_ctl_regs u_rail_ctl_regs (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rail_en(rail_en),
    .boost_en(boost_en), .neg_lvl(neg_lvl), .hi_lvl(hi_lvl), .vsel(vsel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  function automatic logic [2:0] dec(input logic [1:0] c);
    return c == 2'd0 ? 3'b001 : (c == 2'd1 ? 3'b010 : 3'b100);
  endfunction

  task automatic outs(input string req, input logic [8:0] en, input logic bst,
                      input logic [2:0] n, input logic [2:0] h, input logic [4:0] s);
    chk({req, " rail_en"}, rail_en, en);
    chk({req, " boost_en"}, boost_en, bst);
    chk({req, " neg_lvl"}, neg_lvl, n);
    chk({req, " hi_lvl"}, hi_lvl, h);
    chk({req, " vsel"}, vsel, s);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    hw_reset();
    // R1 reset state
    outs("R1", 9'd0, 1'b0, 3'b001, 3'b001, 5'd0);
    rd("R1 id", 8'h00, 8'h20);
    for (int a = 1; a <= 4; a++) rd("R1 reg", 8'(a), 8'h00);

    // R2 only bit 0 of 00h stored (bit 0 clear -> no soft reset)
    wr(8'h00, 8'hFE);
    rd("R2", 8'h00, 8'h20);

    // R3 sweep 01h
    for (int d = 0; d < 256; d++) begin
      wr(8'h01, 8'(d));
      rd("R3 rb", 8'h01, 8'(d) & 8'h7F);
      chk("R3 en", rail_en, {2'b00, 7'(d)});
    end
    wr(8'h01, 8'h00);

    // R4 sweep 04h
    for (int d = 0; d < 256; d++) begin
      wr(8'h04, 8'(d));
      rd("R4 rb", 8'h04, 8'(d) & 8'h0D);
      chk("R4 en", rail_en, {d[3], d[2], 7'd0});
      chk("R4 boost", boost_en, d[0]);
    end

    // R5 sweep 02h
    for (int d = 0; d < 256; d++) begin
      wr(8'h02, 8'(d));
      rd("R5 rb", 8'h02, 8'(d) & 8'hF0);
      chk("R5 neg", neg_lvl, dec(d[7:6]));
      chk("R5 hi", hi_lvl, dec(d[5:4]));
    end

    // R6 sweep 03h
    for (int d = 0; d < 256; d++) begin
      wr(8'h03, 8'(d));
      rd("R6 rb", 8'h03, 8'(d) & 8'hE5);
      chk("R6 vsel", vsel, {d[7], d[6], d[5], d[2], d[0]});
    end

    // R11 reserved addresses
    wr(8'h01, 8'h55); wr(8'h02, 8'h60); wr(8'h03, 8'hA1); wr(8'h04, 8'h09);
    for (int a = 5; a <= 7; a++) begin
      wr(8'(a), 8'hFF);
      outs("R11", 9'h155, 1'b1, 3'b010, 3'b100, 5'b10101);
      rd("R11 rsv", 8'(a), 8'h00);
      rd("R11 r01", 8'h01, 8'h55);
      rd("R11 r02", 8'h02, 8'h60);
      rd("R11 r03", 8'h03, 8'hA1);
      rd("R11 r04", 8'h04, 8'h09);
      rd("R11 id", 8'h00, 8'h20);
    end

    // R7 soft reset clears
    wr(8'h00, 8'h01);
    rd("R7 id", 8'h00, 8'h21);
    for (int a = 1; a <= 4; a++) rd("R7 reg", 8'(a), 8'h00);
    outs("R7", 9'd0, 1'b0, 3'b001, 3'b001, 5'd0);
    chk("R12 srst", rail_en, 9'd0);

    // R8 lockout then release
    wr(8'h01, 8'h7F); wr(8'h04, 8'h0D); wr(8'h02, 8'hF0);
    rd("R8 lock01", 8'h01, 8'h00);
    rd("R8 lock04", 8'h04, 8'h00);
    outs("R8 lock", 9'd0, 1'b0, 3'b001, 3'b001, 5'd0);
    wr(8'h00, 8'h00);
    rd("R8 id", 8'h00, 8'h20);
    rd("R8 held", 8'h01, 8'h00);
    wr(8'h01, 8'h7F);
    rd("R8 rel", 8'h01, 8'h7F);
    chk("R8 en", rail_en, 9'h07F);

    // R9 hardware reset cancels soft reset
    wr(8'h00, 8'h01);
    hw_reset();
    rd("R9 id", 8'h00, 8'h20);
    wr(8'h01, 8'h12);
    rd("R9 wr ok", 8'h01, 8'h12);

    // R10 / R12 undervoltage
    wr(8'h04, 8'h0D); wr(8'h02, 8'h50);
    @(negedge clk); uvlo = 1'b1;
    @(negedge clk);
    outs("R12 uvlo", 9'd0, 1'b0, 3'b001, 3'b001, 5'd0);
    wr(8'h01, 8'h7F);
    rd("R10 r01", 8'h01, 8'h00);
    rd("R10 r04", 8'h04, 8'h00);
    rd("R10 id", 8'h00, 8'h20);
    uvlo = 1'b0;
    wr(8'h01, 8'h03);
    chk("R10 after", rail_en, 9'h003);
    wr(8'h00, 8'h01);
    @(negedge clk); uvlo = 1'b1;
    @(negedge clk); @(negedge clk); uvlo = 1'b0;
    @(negedge clk);
    rd("R10 keep srst", 8'h00, 8'h21);
    chk("R12 srst hold", rail_en, 9'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule